// File: doc/BRIEF.md
# Band-Limited Tuning Word Path for a Digital Synthesizer

This block sits between a control loop and the phase generator of a direct digital synthesizer. Every sample clock it takes a fresh 48-bit frequency word from the loop and clamps it between a programmable ceiling and floor. It then accumulates the clamped word into a 48-bit phase register that wraps. The most significant phase bits go out as an address for a sine lookup. Because the clamp bounds the frequency, the synthesized tone cannot leave a chosen band. A narrow-band reconstruction filter centred on the nominal frequency therefore always passes a feedback signal.

The two bounds are programmed through a staging interface. Software writes the ceiling or the floor into a holding register. A single commit strobe then copies both holding registers into the active bounds in the same cycle, so the clamp never works with a half-updated pair. Two sticky flags record that the ceiling or the floor was hit since the status was last read. A read strobe clears them.

Top module: `dds_band_tuner`

## Requirements
- R1: After reset the active ceiling is 2^47 (only bit 47 set) and the active floor is 0, and so are both holding registers. `ftw_eff`, `phase_out`, `clip_hi` and `clip_lo` are all zero.
- R2: An input word with floor <= word <= ceiling appears unchanged on `ftw_eff` one clock after it is sampled.
- R3: An input word above the ceiling yields the ceiling on `ftw_eff` one clock later and sets `clip_hi` in that same clock.
- R4: An input word below the floor, with floor <= ceiling, yields the floor on `ftw_eff` one clock later and sets `clip_lo` in that same clock.
- R5: If the floor is programmed above the ceiling, `ftw_eff` equals the ceiling for every input word and `clip_hi` is set.
- R6: On every clock the phase register adds the current `ftw_eff`, modulo 2^48. `phase_out` is bits 47:34 of that register.
- R7: `clip_hi` and `clip_lo` stay set until a clock with `stat_rd` high clears them. A clip event in the same clock as the read leaves its flag set.
- R8: A write with `lim_wr` high loads `lim_wdata` into a holding register: the ceiling when `lim_sel` is 0, the floor when `lim_sel` is 1. The write does not change the clamp. When `lim_commit` is high, both holding registers, as they were before that edge, become the active bounds together.
- R9: All comparisons are unsigned. A word with bit 47 set is greater than 2^47 - 1, so under the reset bounds any word above 2^47 is clipped to 2^47.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ftw_in | input | 48 | Frequency word from the control loop, sampled every clock |
| lim_wr | input | 1 | Write strobe for a holding register |
| lim_sel | input | 1 | Holding register select: 0 ceiling, 1 floor |
| lim_wdata | input | 48 | Value written to the selected holding register |
| lim_commit | input | 1 | Copies both holding registers into the active bounds |
| stat_rd | input | 1 | Status read strobe, clears the sticky flags |
| ftw_eff | output | 48 | Clamped frequency word in use by the accumulator |
| phase_out | output | 14 | Truncated phase for the sine lookup |
| clip_hi | output | 1 | Sticky flag: ceiling was applied |
| clip_lo | output | 1 | Sticky flag: floor was applied |

## Verification
On every cycle the assertions check four things. The applied word never exceeds the ceiling, and it never falls below a consistent floor. An in-band word passes through unchanged. The phase register steps by exactly the applied word. They also check that the bounds move only on a commit and that a flag stays set unless a read clears it. Only the bench's scenarios can show the values that are actually expected. These cover the reset defaults, wrap-around of the phase after several steps, the outcome when the floor is above the ceiling, and a write that is held back until its commit. They also cover the unsigned treatment of words with bit 47 set and the rule that an event in the same cycle as a read keeps its flag.

// File: rtl/dds_band_pkg.sv
package dds_band_pkg;
  localparam int unsigned WORD_W  = 48;
  localparam int unsigned PHASE_W = 14;

  typedef enum logic {
    SEL_CEIL  = 1'b0,
    SEL_FLOOR = 1'b1
  } bound_sel_e;

  typedef struct packed {
    logic hit_ceil;
    logic hit_floor;
  } clip_ev_t;
endpackage

// File: rtl/dds_bound_regs.sv
module dds_bound_regs
  import dds_band_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         commit,
  output logic [W-1:0] ceil_act,
  output logic [W-1:0] floor_act
);
  localparam logic [W-1:0] CEIL_RST  = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] FLOOR_RST = '0;

  logic [W-1:0] ceil_hold_q, ceil_hold_d;
  logic [W-1:0] floor_hold_q, floor_hold_d;
  logic [W-1:0] ceil_act_q, ceil_act_d;
  logic [W-1:0] floor_act_q, floor_act_d;
  logic         ceil_wr_en, floor_wr_en;

  assign ceil_wr_en  = wr_en && (bound_sel_e'(wr_sel) == SEL_CEIL);
  assign floor_wr_en = wr_en && (bound_sel_e'(wr_sel) == SEL_FLOOR);

  always_comb begin
    ceil_hold_d  = ceil_hold_q;
    floor_hold_d = floor_hold_q;
    ceil_act_d   = ceil_act_q;
    floor_act_d  = floor_act_q;
    if (ceil_wr_en)  ceil_hold_d  = wr_data;
    if (floor_wr_en) floor_hold_d = wr_data;
    if (commit) begin
      ceil_act_d  = ceil_hold_q;
      floor_act_d = floor_hold_q;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ceil_hold_q  <= CEIL_RST;
      floor_hold_q <= FLOOR_RST;
      ceil_act_q   <= CEIL_RST;
      floor_act_q  <= FLOOR_RST;
    end else begin
      ceil_hold_q  <= ceil_hold_d;
      floor_hold_q <= floor_hold_d;
      ceil_act_q   <= ceil_act_d;
      floor_act_q  <= floor_act_d;
    end
  end

  assign ceil_act  = ceil_act_q;
  assign floor_act = floor_act_q;
endmodule

// File: rtl/dds_word_clamp.sv
module dds_word_clamp
  import dds_band_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] word_in,
  input  logic [W-1:0] ceil_val,
  input  logic [W-1:0] floor_val,
  output logic [W-1:0] word_out,
  output clip_ev_t     clip_ev
);
  logic [W-1:0] raised;
  logic [W-1:0] word_d, word_q;
  logic         below_floor, above_ceil;
  clip_ev_t     ev_d, ev_q;

  always_comb begin
    below_floor = word_in < floor_val;
    raised      = below_floor ? floor_val : word_in;
    above_ceil  = raised > ceil_val;
    word_d      = above_ceil ? ceil_val : raised;
    ev_d.hit_ceil  = above_ceil;
    ev_d.hit_floor = below_floor && !above_ceil;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      word_q <= '0;
      ev_q   <= '0;
    end else begin
      word_q <= word_d;
      ev_q   <= ev_d;
    end
  end

  assign word_out = word_q;
  assign clip_ev  = ev_d;
endmodule

// File: rtl/dds_phase_accum.sv
module dds_phase_accum
  import dds_band_pkg::*;
#(
  parameter int unsigned W  = WORD_W,
  parameter int unsigned PW = PHASE_W
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic [W-1:0]  step,
  output logic [W-1:0]  acc,
  output logic [PW-1:0] phase
);
  localparam int unsigned TOP_LSB = W - PW;

  logic [W-1:0] acc_q, acc_d;

  always_comb acc_d = acc_q + step;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign acc   = acc_q;
  assign phase = acc_q[W-1:TOP_LSB];
endmodule

// File: rtl/dds_clip_status.sv
module dds_clip_status
  import dds_band_pkg::*;
(
  input  logic     clk,
  input  logic     arst_n,
  input  clip_ev_t ev,
  input  logic     rd,
  output logic     flag_ceil,
  output logic     flag_floor
);
  clip_ev_t sticky_q, sticky_d;

  always_comb begin
    sticky_d.hit_ceil  = ev.hit_ceil  | (sticky_q.hit_ceil  & ~rd);
    sticky_d.hit_floor = ev.hit_floor | (sticky_q.hit_floor & ~rd);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sticky_q <= '0;
    else         sticky_q <= sticky_d;
  end

  assign flag_ceil  = sticky_q.hit_ceil;
  assign flag_floor = sticky_q.hit_floor;
endmodule

// File: rtl/dds_band_tuner.sv
module dds_band_tuner
  import dds_band_pkg::*;
#(
  parameter int unsigned FTW_W   = WORD_W,
  parameter int unsigned PHS_W   = PHASE_W,
  parameter int unsigned RST_STG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FTW_W-1:0] ftw_in,
  input  logic             lim_wr,
  input  logic             lim_sel,
  input  logic [FTW_W-1:0] lim_wdata,
  input  logic             lim_commit,
  input  logic             stat_rd,
  output logic [FTW_W-1:0] ftw_eff,
  output logic [PHS_W-1:0] phase_out,
  output logic             clip_hi,
  output logic             clip_lo
);
  logic [RST_STG-1:0] rst_pipe_q;
  logic               arst_n;
  logic [FTW_W-1:0]   hi_act, lo_act, acc_q;
  clip_ev_t           clip_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STG-2:0], 1'b1};
  end
  assign arst_n = rst_pipe_q[RST_STG-1];

  dds_bound_regs #(.W(FTW_W)) u_bounds (
    .clk(clk), .arst_n(arst_n), .wr_en(lim_wr), .wr_sel(lim_sel),
    .wr_data(lim_wdata), .commit(lim_commit),
    .ceil_act(hi_act), .floor_act(lo_act)
  );

  dds_word_clamp #(.W(FTW_W)) u_clamp (
    .clk(clk), .arst_n(arst_n), .word_in(ftw_in),
    .ceil_val(hi_act), .floor_val(lo_act),
    .word_out(ftw_eff), .clip_ev(clip_ev)
  );

  dds_phase_accum #(.W(FTW_W), .PW(PHS_W)) u_accum (
    .clk(clk), .arst_n(arst_n), .step(ftw_eff),
    .acc(acc_q), .phase(phase_out)
  );

  dds_clip_status u_status (
    .clk(clk), .arst_n(arst_n), .ev(clip_ev), .rd(stat_rd),
    .flag_ceil(clip_hi), .flag_floor(clip_lo)
  );
endmodule

// File: rtl/dds_band_tuner_chk.sv
module dds_band_tuner_chk #(
  parameter int unsigned W = 48
) (
  input logic         clk,
  input logic         arst_n,
  input logic [W-1:0] ftw_in,
  input logic         lim_commit,
  input logic         stat_rd,
  input logic [W-1:0] hi_act,
  input logic [W-1:0] lo_act,
  input logic [W-1:0] ftw_eff,
  input logic [W-1:0] acc,
  input logic         clip_hi,
  input logic         clip_lo
);
  AST_EFF_UNDER_CEIL: assert property (@(posedge clk) disable iff (!arst_n)
    1'b1 |=> ftw_eff <= $past(hi_act)); // R3
  AST_EFF_OVER_FLOOR: assert property (@(posedge clk) disable iff (!arst_n)
    (lo_act <= hi_act) |=> ftw_eff >= $past(lo_act)); // R4
  AST_INBAND_PASS: assert property (@(posedge clk) disable iff (!arst_n)
    (ftw_in >= lo_act && ftw_in <= hi_act) |=> ftw_eff == $past(ftw_in)); // R2
  AST_ACCUM_STEP: assert property (@(posedge clk) disable iff (!arst_n)
    1'b1 |=> acc == $past(acc) + $past(ftw_eff)); // R6
  AST_BOUNDS_HELD: assert property (@(posedge clk) disable iff (!arst_n)
    !lim_commit |=> $stable(hi_act) && $stable(lo_act)); // R8
  AST_CEIL_STICKY: assert property (@(posedge clk) disable iff (!arst_n)
    (clip_hi && !stat_rd) |=> clip_hi); // R7
  AST_FLOOR_STICKY: assert property (@(posedge clk) disable iff (!arst_n)
    (clip_lo && !stat_rd) |=> clip_lo); // R7
  AST_INVERTED_CEIL: assert property (@(posedge clk) disable iff (!arst_n)
    (lo_act > hi_act) |=> (ftw_eff == $past(hi_act)) && clip_hi); // R5
endmodule

bind dds_band_tuner dds_band_tuner_chk #(.W(FTW_W)) u_chk (
  .clk(clk), .arst_n(arst_n), .ftw_in(ftw_in), .lim_commit(lim_commit),
  .stat_rd(stat_rd), .hi_act(hi_act), .lo_act(lo_act), .ftw_eff(ftw_eff),
  .acc(acc_q), .clip_hi(clip_hi), .clip_lo(clip_lo)
);

// File: tb/test_dds_band_tuner.sv
`timescale 1ns/1ps
module test_dds_band_tuner;
  localparam int W = 48;
  localparam logic [W-1:0] HALF = 48'h8000_0000_0000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] ftw_in;
  logic         lim_wr, lim_sel, lim_commit, stat_rd;
  logic [W-1:0] lim_wdata;
  logic [W-1:0] ftw_eff;
  logic [13:0]  phase_out;
  logic         clip_hi, clip_lo;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dds_band_tuner i_dds_band_tuner (
    .clk(clk), .rst_n(rst_n), .ftw_in(ftw_in), .lim_wr(lim_wr),
    .lim_sel(lim_sel), .lim_wdata(lim_wdata), .lim_commit(lim_commit),
    .stat_rd(stat_rd), .ftw_eff(ftw_eff), .phase_out(phase_out),
    .clip_hi(clip_hi), .clip_lo(clip_lo)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: edge happens, then we are at the following negedge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ftw_in = '0; lim_wr = 0; lim_sel = 0; lim_wdata = '0;
    lim_commit = 0; stat_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step();
  endtask

  task automatic set_bounds(input logic [W-1:0] hi, input logic [W-1:0] lo);
    lim_wr = 1; lim_sel = 0; lim_wdata = hi; step();
    lim_sel = 1; lim_wdata = lo; step();
    lim_wr = 0; lim_commit = 1; step();
    lim_commit = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 ftw_eff", ftw_eff, '0);
    chk("R1 phase", {34'd0, phase_out}, '0);
    chk("R1 flags", {46'd0, clip_hi, clip_lo}, '0);
    ftw_in = HALF; step();
    chk("R1 default ceiling passes 2^47", ftw_eff, HALF);
    chk("R1 no clip at 2^47", {47'd0, clip_hi}, '0);
  endtask

  task automatic t_passthrough();
    do_reset();
    ftw_in = 48'h1234_5678_9ABC; step();
    chk("R2 pass a", ftw_eff, 48'h1234_5678_9ABC);
    ftw_in = 48'h0000_0000_0001; step();
    chk("R2 pass b", ftw_eff, 48'h1);
    chk("R2 no flags", {46'd0, clip_hi, clip_lo}, '0);
  endtask

  task automatic t_ceiling_unsigned();
    do_reset();
    ftw_in = 48'hFFFF_FFFF_FFFF; step();
    chk("R9 all-ones clipped", ftw_eff, HALF);
    chk("R3 clip_hi set", {47'd0, clip_hi}, 48'd1);
    ftw_in = HALF + 48'd5; step();
    chk("R9 just above 2^47", ftw_eff, HALF);
    set_bounds(48'h0000_9000_0000, 48'h0000_1000_0000);
    ftw_in = 48'h0000_9000_0001; step();
    chk("R3 programmed ceiling", ftw_eff, 48'h0000_9000_0000);
    ftw_in = 48'h0000_9000_0000; step();
    chk("R2 equal to ceiling passes", ftw_eff, 48'h0000_9000_0000);
  endtask

  task automatic t_floor();
    do_reset();
    set_bounds(48'h0000_9600_0000, 48'h0000_8A00_0000);
    ftw_in = 48'h0000_0000_0003; step();
    chk("R4 floor applied", ftw_eff, 48'h0000_8A00_0000);
    chk("R4 clip_lo set", {47'd0, clip_lo}, 48'd1);
    chk("R4 clip_hi clear", {47'd0, clip_hi}, '0);
    ftw_in = 48'h0000_8A00_0000; step();
    chk("R2 equal to floor passes", ftw_eff, 48'h0000_8A00_0000);
  endtask

  task automatic t_inverted();
    do_reset();
    set_bounds(48'd500, 48'd1000);
    ftw_in = 48'd0; step();
    chk("R5 input 0", ftw_eff, 48'd500);
    ftw_in = 48'd700; step();
    chk("R5 input between", ftw_eff, 48'd500);
    ftw_in = 48'd2000; step();
    chk("R5 input above", ftw_eff, 48'd500);
    chk("R5 clip_hi", {47'd0, clip_hi}, 48'd1);
  endtask

  task automatic t_accum();
    logic [W-1:0] f;
    logic [W-1:0] exp_acc;
    do_reset();
    f = 48'h7000_0000_0001;
    ftw_in = f; step(); // edge 1: eff=f, acc=0
    chk("R6 acc after first edge", {34'd0, phase_out}, '0);
    for (int k = 2; k <= 7; k++) begin
      step();
      exp_acc = f * (k - 1);
      chk("R6 phase wrap", {34'd0, phase_out}, {34'd0, exp_acc[47:34]});
    end
  endtask

  task automatic t_sticky();
    do_reset();
    set_bounds(48'h0000_9600_0000, 48'h0000_8A00_0000);
    ftw_in = 48'h0000_FFFF_0000; step();
    ftw_in = 48'h0000_9000_0000; repeat (3) step();
    chk("R7 clip_hi held", {47'd0, clip_hi}, 48'd1);
    stat_rd = 1; step(); stat_rd = 0;
    chk("R7 cleared by read", {47'd0, clip_hi}, '0);
    ftw_in = 48'h0000_0000_0010; step();
    ftw_in = 48'h0000_9000_0000; step();
    chk("R7 clip_lo held", {47'd0, clip_lo}, 48'd1);
    ftw_in = 48'h0000_0000_0010; stat_rd = 1; step(); stat_rd = 0;
    chk("R7 event with read keeps flag", {47'd0, clip_lo}, 48'd1);
    ftw_in = 48'h0000_9000_0000; stat_rd = 1; step(); stat_rd = 0;
    chk("R7 clip_lo cleared", {47'd0, clip_lo}, '0);
  endtask

  task automatic t_staging();
    do_reset();
    lim_wr = 1; lim_sel = 0; lim_wdata = 48'h0000_0000_1000; step();
    lim_sel = 1; lim_wdata = 48'h0000_0000_0800; step(); lim_wr = 0;
    ftw_in = 48'h0000_0000_4000; step();
    chk("R8 staged ceiling ignored", ftw_eff, 48'h0000_0000_4000);
    ftw_in = 48'h0000_0000_0010; step();
    chk("R8 staged floor ignored", ftw_eff, 48'h0000_0000_0010);
    lim_commit = 1; step(); lim_commit = 0;
    ftw_in = 48'h0000_0000_4000; step();
    chk("R8 ceiling after commit", ftw_eff, 48'h0000_0000_1000);
    ftw_in = 48'h0000_0000_0010; step();
    chk("R8 floor after commit", ftw_eff, 48'h0000_0000_0800);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_passthrough();
        t_ceiling_unsigned();
        t_floor();
        t_inverted();
        t_accum();
        t_sticky();
        t_staging();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule